// File: doc/BRIEF.md
# UART FIFO Status Flag Logic

This block keeps two sticky status flags for a serial port that has transmit and receive FIFOs. The first is a transmit-space flag. It goes high when the transmit FIFO has drained to or below a level picked by a 2-bit trigger select. The second is a break flag. It goes high when a frame with a framing error is followed by the receive line staying low for a whole frame time.

Software clears either flag under a read-before-clear rule. It must first read the flag while it is 1, and then write 0 to that bit. A write of 0 with no such read has no effect. The transmit flag has two further rules. It is forced high again for as long as the FIFO level stays at or below the trigger. A DMA write that leaves the FIFO above the trigger clears it directly, with no read or write step.

Each flag has its own enable. The interrupt request is the OR of the enabled flags. Every pin is a plain control or status signal sampled on the clock. There is no data stream and no handshake.

Top module: `uart_flag_unit`

## Requirements
- R1: On reset the transmit-space flag is 1 and the break flag is 0.
- R2: Trigger select 00, 01, 10 and 11 means levels 8, 4, 2 and 0 (FIFO depth 16). Whenever the FIFO count is at or below the selected level, the transmit-space flag is 1 on the next cycle.
- R3: A write with bit 0 equal to 0 clears the transmit-space flag only if an earlier read returned the flag as 1 and the FIFO count is above the trigger. That write uses up the arming. A write of 0 without arming leaves the flag unchanged.
- R4: A DMA write strobe while the FIFO count is above the trigger clears the transmit-space flag on the next cycle, with no read needed.
- R5: Writing 1 to either flag bit has no effect, and it does not use up the arming.
- R6: After a framing error, 10 bit-time ticks with the receive line held low set the break flag. Nine ticks do not set it.
- R7: A high receive line restarts the tick count and cancels the pending framing error, so a break needs a new framing error.
- R8: Only one break is reported per low period. Once the flag is cleared, further ticks in the same low period do not set it again.
- R9: A write with bit 1 equal to 0 clears the break flag only after a read that returned the flag as 1. Without that read the write is ignored.
- R10: irq is (transmit-space flag AND its enable) OR (break flag AND its enable).
- R11: Read data bit 0 carries the transmit-space flag and bit 1 carries the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_count | input | 5 | Transmit FIFO fill count |
| trig_sel | input | 2 | Transmit trigger level select |
| reg_rd | input | 1 | Status register read strobe |
| reg_rdata | output | 2 | Status read data {break, tx space} |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 2 | Status write data |
| dma_wr | input | 1 | DMA has written transmit data this cycle |
| rx_framing_err | input | 1 | Received frame had a framing error |
| rx_line | input | 1 | Sampled receive line level |
| bit_tick | input | 1 | One pulse per bit time |
| txe_ie | input | 1 | Transmit-space interrupt enable |
| brk_ie | input | 1 | Break interrupt enable |
| txe_flag | output | 1 | Transmit-space flag |
| brk_flag | output | 1 | Break flag |
| irq | output | 1 | Interrupt request |

## Verification
The transmit flag is driven at the trigger boundary for every select code, with counts both equal to and one above the level. This separates the "at or below" rule from a strict "below" rule, and it catches a wrong level mapping. Clear attempts come in three forms: a write of 0 with no read, a write of 1 after a read, and a read followed by a write of 0. These show apart a missing arming latch, an arming that a 1 wrongly uses up, and a clear that never takes effect. On the receive side, low periods of nine and ten ticks check the exact break length. A low period broken by a high level shows whether the count restarts and whether the pending framing error is dropped. Extra ticks after a clear confirm that a break is reported only once per low period.

// File: rtl/uflag_pkg.sv
package uflag_pkg;
  localparam int FLAG_W  = 2;
  localparam int TXE_BIT = 0;
  localparam int BRK_BIT = 1;

  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tx_level_cmp.sv
module tx_level_cmp #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic [1:0]    sel,
  output logic          at_or_below
);
  logic [CW-1:0] level;

  always_comb begin
    level       = CW'(uflag_pkg::trig_level(sel, DEPTH));
    at_or_below = (count <= level);
  end
endmodule

// File: rtl/break_timer.sv
module break_timer #(
  parameter int FRAME_TICKS = 10,
  localparam int TW = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic framing_err,
  input  logic line,
  input  logic tick,
  output logic brk_evt
);
  logic          pend_q;
  logic          rep_q;
  logic [TW-1:0] cnt_q;
  logic          counting;

  assign counting = pend_q && !line && !rep_q;
  assign brk_evt  = tick && counting && (cnt_q == TW'(FRAME_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rep_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= framing_err || (pend_q && !line);
      if (line) begin
        cnt_q <= '0;
        rep_q <= 1'b0;
      end else if (brk_evt) begin
        cnt_q <= '0;
        rep_q <= 1'b1;
      end else if (tick && counting) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: a high line restarts the length count
  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line |=> (cnt_q == '0));
  // R8: one report per low period
  p_one_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt);
endmodule

// File: rtl/rbc_flag.sv
module rbc_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  output logic flag_o
);
  logic arm_q;
  logic sw_clr;

  assign sw_clr = wr_zero_i && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                  flag_o <= 1'b1;
      else if (sw_clr || hw_clr_i) flag_o <= 1'b0;

      if (sw_clr)              arm_q <= 1'b0;
      else if (rd_i && flag_o) arm_q <= 1'b1;
      else if (!flag_o)        arm_q <= 1'b0;
    end
  end

  // R2/R6: a set request always wins
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R3/R9: an unarmed write-zero leaves the flag alone
  p_unarmed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !hw_clr_i && !set_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit #(
  parameter int FIFO_DEPTH  = 16,
  parameter int FRAME_TICKS = 10,
  localparam int CW = $clog2(FIFO_DEPTH + 1),
  localparam int FW = uflag_pkg::FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic [1:0]    trig_sel,
  input  logic          reg_rd,
  output logic [FW-1:0] reg_rdata,
  input  logic          reg_wr,
  input  logic [FW-1:0] reg_wdata,
  input  logic          dma_wr,
  input  logic          rx_framing_err,
  input  logic          rx_line,
  input  logic          bit_tick,
  input  logic          txe_ie,
  input  logic          brk_ie,
  output logic          txe_flag,
  output logic          brk_flag,
  output logic          irq
);
  import uflag_pkg::*;

  logic lvl_low;
  logic brk_evt;
  logic [FW-1:0] wr_zero;

  tx_level_cmp #(.DEPTH(FIFO_DEPTH)) u_cmp (
    .count(tx_count), .sel(trig_sel), .at_or_below(lvl_low)
  );

  break_timer #(.FRAME_TICKS(FRAME_TICKS)) u_brk_tmr (
    .clk(clk), .rst_n(rst_n), .framing_err(rx_framing_err),
    .line(rx_line), .tick(bit_tick), .brk_evt(brk_evt)
  );

  genvar g;
  generate
    for (g = 0; g < FW; g++) begin : g_wz
      assign wr_zero[g] = reg_wr && !reg_wdata[g];
    end
  endgenerate

  rbc_flag #(.RST_VAL(1'b1)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(lvl_low),
    .hw_clr_i(dma_wr && !lvl_low), .rd_i(reg_rd),
    .wr_zero_i(wr_zero[TXE_BIT]), .flag_o(txe_flag)
  );

  rbc_flag #(.RST_VAL(1'b0)) u_brk (
    .clk(clk), .rst_n(rst_n), .set_i(brk_evt),
    .hw_clr_i(1'b0), .rd_i(reg_rd),
    .wr_zero_i(wr_zero[BRK_BIT]), .flag_o(brk_flag)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[TXE_BIT] = txe_flag;
    reg_rdata[BRK_BIT] = brk_flag;
    irq = (txe_flag && txe_ie) || (brk_flag && brk_ie);
  end

  // R4: DMA write above trigger clears the transmit flag
  p_dma_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !lvl_low) |=> !txe_flag);
  // R10: no request while both sources are masked
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!txe_ie && !brk_ie) |-> !irq);
endmodule

// File: tb/uart_flag_unit_bench.sv
`timescale 1ns/1ps
module uart_flag_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] tx_count = 5'd12;
  logic [1:0] trig_sel = 2'd0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, dma_wr = 1'b0;
  logic [1:0] reg_wdata = 2'b11;
  logic rx_framing_err = 1'b0, rx_line = 1'b1, bit_tick = 1'b0;
  logic txe_ie = 1'b1, brk_ie = 1'b0;
  logic [1:0] reg_rdata;
  logic txe_flag, brk_flag, irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_flag_unit u_uart_flag_unit (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .trig_sel(trig_sel),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .dma_wr(dma_wr), .rx_framing_err(rx_framing_err),
    .rx_line(rx_line), .bit_tick(bit_tick), .txe_ie(txe_ie), .brk_ie(brk_ie),
    .txe_flag(txe_flag), .brk_flag(brk_flag), .irq(irq)
  );

  // behavioural reference model
  int m_txe, m_tarm, m_brk, m_barm, m_pend, m_ticks, m_done;
  int lvl, below, evt, n_txe, n_tarm, n_brk, n_barm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txe = 1; m_tarm = 0; m_brk = 0; m_barm = 0;
      m_pend = 0; m_ticks = 0; m_done = 0;
    end else begin
      lvl   = (trig_sel == 3) ? 0 : (16 >> (trig_sel + 1));
      below = (tx_count <= lvl);
      evt   = bit_tick && m_pend && !rx_line && !m_done && (m_ticks == 9);
      n_txe = m_txe; n_tarm = m_tarm; n_brk = m_brk; n_barm = m_barm;
      if (reg_wr && !reg_wdata[0] && m_tarm) begin n_txe = 0; n_tarm = 0; end
      else if (reg_rd && m_txe) n_tarm = 1;
      else if (!m_txe) n_tarm = 0;
      if (dma_wr) n_txe = 0;
      if (below) n_txe = 1;
      if (reg_wr && !reg_wdata[1] && m_barm) begin n_brk = 0; n_barm = 0; end
      else if (reg_rd && m_brk) n_barm = 1;
      else if (!m_brk) n_barm = 0;
      if (evt) n_brk = 1;
      if (rx_line) begin m_ticks = 0; m_done = 0; end
      else if (evt) begin m_ticks = 0; m_done = 1; end
      else if (bit_tick && m_pend && !m_done) m_ticks++;
      m_pend = rx_framing_err || (m_pend && !rx_line);
      m_txe = n_txe; m_tarm = n_tarm; m_brk = n_brk; m_barm = n_barm;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("R2 txe_flag model", txe_flag, m_txe);
    check("R6 brk_flag model", brk_flag, m_brk);
    check("R10 irq model", irq, (m_txe && txe_ie) || (m_brk && brk_ie));
    check("R11 rdata model", reg_rdata, (m_brk << 1) | m_txe);
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic rd(); reg_rd = 1; cyc(); reg_rd = 0; endtask
  task automatic wr(input logic [1:0] v);
    reg_wr = 1; reg_wdata = v; cyc(); reg_wr = 0; reg_wdata = 2'b11;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cyc(); bit_tick = 0; cyc(); end
  endtask
  task automatic fe_pulse();
    rx_framing_err = 1; rx_line = 0; cyc(); rx_framing_err = 0;
  endtask
  task automatic settle(); @(negedge clk); #1; endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    check("R1 reset txe", txe_flag, 1);
    check("R1 reset brk", brk_flag, 0);
    check("R11 reset rdata", reg_rdata, 1);
    wr(2'b00); settle();
    check("R3 unarmed write", txe_flag, 1);
    rd(); wr(2'b10); settle();
    check("R3 armed clear", txe_flag, 0);
    check("R5 brk write one", brk_flag, 0);
    tx_count = 8; cyc(); settle();
    check("R2 boundary 8", txe_flag, 1);
    trig_sel = 1; tx_count = 5;
    rd(); wr(2'b01); settle();
    check("R5 txe write one", txe_flag, 1);
    wr(2'b10); settle();
    check("R3 arm kept by one", txe_flag, 0);
    tx_count = 4; cyc(); settle();
    check("R2 boundary 4", txe_flag, 1);
    trig_sel = 3; tx_count = 1; rd(); wr(2'b10); settle();
    check("R3 clear code 11", txe_flag, 0);
    tx_count = 0; cyc(); settle();
    check("R2 boundary 0", txe_flag, 1);
    trig_sel = 2; tx_count = 3; dma_wr = 1; cyc(); dma_wr = 0; settle();
    check("R4 dma clear", txe_flag, 0);
    tx_count = 2; cyc(); settle();
    check("R2 boundary 2", txe_flag, 1);
    tx_count = 3; rd(); wr(2'b10); tx_count = 2; cyc(); tx_count = 3;
    wr(2'b10); settle();
    check("R3 arming used up", txe_flag, 1);
    txe_ie = 0; cyc(); settle();
    check("R10 txe masked", irq, 0);
    fe_pulse(); ticks(9); settle();
    check("R6 nine ticks", brk_flag, 0);
    ticks(1); settle();
    check("R6 ten ticks", brk_flag, 1);
    brk_ie = 1; cyc(); settle();
    check("R10 brk enabled", irq, 1);
    check("R11 both flags", reg_rdata, 3);
    wr(2'b01); settle();
    check("R9 unarmed brk write", brk_flag, 1);
    rd(); wr(2'b01); settle();
    check("R9 armed brk clear", brk_flag, 0);
    ticks(12); settle();
    check("R8 no second report", brk_flag, 0);
    rx_line = 1; cyc();
    fe_pulse(); ticks(6); rx_line = 1; cyc(); rx_line = 0; ticks(6); settle();
    check("R7 pend dropped", brk_flag, 0);
    rx_line = 1; cyc();
    fe_pulse(); ticks(6); rx_line = 1; cyc(); fe_pulse(); ticks(9); settle();
    check("R7 count restarted", brk_flag, 0);
    ticks(1); settle();
    check("R7 full length after restart", brk_flag, 1);
    rx_line = 1; cyc(); settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule